// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Coder

This block turns the transmit side of a nibble-wide media-independent interface into a three-level line symbol stream, one symbol per clock at 125 Mbaud. Every five clocks it samples one nibble together with the frame enable and error strobes. It chooses a 5-bit code group: a data group from the 4B/5B table, a start or end delimiter, an error group or idle. It then shifts that group out most significant bit first. Each bit is whitened with an 11-bit scrambler before MLT-3 coding drives a two-bit signed level code.

A raw mode lets a test or link-layer engine supply pre-scrambled 5-bit groups directly. In that mode the error strobe acts as the fifth, top bit, the frame enable has no effect, and the coder neither frames, maps nor scrambles. The raw mode is honoured only while the auto-negotiation enable input is low.

Top module: `mlt3_tx_path`

## Requirements
- R1: While reset is asserted and after its release, the line level is 0 and nib_ack is low. The first group sent is idle (11111), the scrambler starts at all ones, and the MLT-3 phase starts at level 0.
- R2: nib_ack is high in exactly one cycle of every five, starting in the fifth cycle after reset release. The inputs are sampled at the clock edge that ends that cycle, and the chosen group is sent during the next five cycles, most significant bit first.
- R3: Within a frame, a nibble with tx_en high and tx_er low is sent as its 4B/5B data group (0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101).
- R4: The first two samples that have tx_en high after idle are replaced by J (11000) and then K (10001). The K group is sent regardless of tx_en.
- R5: The first sample with tx_en low inside a frame is sent as T (01101), and the next as R (00111). Outside a frame every sample is sent as idle (11111), whatever tx_er and txd are.
- R6: Within a frame, a sample with tx_en and tx_er both high is sent as the error group H (00100).
- R7: The scrambler is an 11-bit register s. Its key s[10]^s[8] is XORed onto each non-raw bit, and the register shifts left, taking the key in, every clock.
- R8: MLT-3 coding steps through the cycle 0, +1, 0, −1 on each scrambled 1 bit and holds on each 0 bit. The level is shown on line_lvl as 00 for 0, 01 for +1 and 11 for −1, one clock after the bit.
- R9: When raw_mode is high and aneg_en is low at a sample, the group is {tx_er, txd[3:0]}, sent unscrambled (the scrambler keeps stepping). tx_en is ignored, and framing returns to idle, so a later frame starts again with J and K.
- R10: While aneg_en is high, raw_mode has no effect and normal framed, scrambled coding applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable |
| tx_er | input | 1 | Error strobe; top bit of the raw group in raw mode |
| txd | input | 4 | Transmit nibble |
| raw_mode | input | 1 | Request for raw pre-scrambled group mode |
| aneg_en | input | 1 | Auto-negotiation enabled; blocks raw mode |
| nib_ack | output | 1 | High in the cycle whose closing edge samples the inputs |
| line_lvl | output | 2 | Signed line level: 00 zero, 01 plus one, 11 minus one |

## Verification
A sample taken at the edge that closes a nib_ack cycle decides the group sent bit by bit over the next five cycles. Each bit shows on line_lvl one clock after its own cycle, so a group's last bit appears in the first cycle of the following slot. The bench steps a model scrambler and level phase one bit per cycle in lockstep with the design. At each falling edge it compares line_lvl against the model state, which includes every bit up to the previous cycle. It also checks nib_ack against the slot position in the same cycle.

// File: rtl/mlt3_tx_path.sv
module mlt3_tx_path #(
  parameter logic [10:0] SCR_SEED = 11'h7FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  input  logic       raw_mode,
  input  logic       aneg_en,
  output logic       nib_ack,
  output logic [1:0] line_lvl
);
  localparam int GW = 5;
  localparam int SW = 11;
  localparam logic [GW-1:0] CG_I = 5'b11111;
  localparam logic [GW-1:0] CG_J = 5'b11000;
  localparam logic [GW-1:0] CG_K = 5'b10001;
  localparam logic [GW-1:0] CG_T = 5'b01101;
  localparam logic [GW-1:0] CG_R = 5'b00111;
  localparam logic [GW-1:0] CG_H = 5'b00100;

  typedef enum logic [1:0] {F_IDLE, F_K, F_DATA, F_R} frm_t;

  frm_t          frm, frm_nx;
  logic [2:0]    cnt;
  logic [GW-1:0] sh, grp_nx;
  logic          raw_q;
  logic [SW-1:0] scr;
  logic [1:0]    ph;
  logic          key, bit_out, raw_now;

  function automatic logic [GW-1:0] enc4b5b(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;
      4'h1: return 5'b01001;
      4'h2: return 5'b10100;
      4'h3: return 5'b10101;
      4'h4: return 5'b01010;
      4'h5: return 5'b01011;
      4'h6: return 5'b01110;
      4'h7: return 5'b01111;
      4'h8: return 5'b10010;
      4'h9: return 5'b10011;
      4'hA: return 5'b10110;
      4'hB: return 5'b10111;
      4'hC: return 5'b11010;
      4'hD: return 5'b11011;
      4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  assign nib_ack = (cnt == 3'(GW - 1));
  assign raw_now = raw_mode & ~aneg_en;
  assign key     = scr[SW-1] ^ scr[SW-3];
  assign bit_out = sh[GW-1] ^ (key & ~raw_q);
  assign line_lvl = ph[0] ? (ph[1] ? 2'b11 : 2'b01) : 2'b00;

  always_comb begin
    frm_nx = frm;
    grp_nx = CG_I;
    if (raw_now) begin
      grp_nx = {tx_er, txd};
      frm_nx = F_IDLE;
    end else begin
      case (frm)
        F_IDLE: if (tx_en) begin
          grp_nx = CG_J;
          frm_nx = F_K;
        end
        F_K: begin
          grp_nx = CG_K;
          frm_nx = F_DATA;
        end
        F_DATA: if (tx_en) begin
          grp_nx = tx_er ? CG_H : enc4b5b(txd);
        end else begin
          grp_nx = CG_T;
          frm_nx = F_R;
        end
        default: begin
          grp_nx = CG_R;
          frm_nx = F_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sh    <= CG_I;
      raw_q <= 1'b0;
      frm   <= F_IDLE;
      scr   <= SCR_SEED;
      ph    <= '0;
    end else begin
      scr <= {scr[SW-2:0], key};
      if (bit_out) ph <= ph + 2'd1;
      if (nib_ack) begin
        cnt   <= '0;
        sh    <= grp_nx;
        raw_q <= raw_now;
        frm   <= frm_nx;
      end else begin
        cnt <= cnt + 3'd1;
        sh  <= {sh[GW-2:0], 1'b0};
      end
    end
  end

  // R2
  nib_ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_ack |=> !nib_ack);

  // R8
  lvl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_lvl != 2'b10);

  // R8
  lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lvl != 2'b00) |=> (line_lvl == $past(line_lvl) || line_lvl == 2'b00));

  // R7
  scr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scr != '0);

  // R4
  k_follows_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_ack && frm == F_K && !raw_now) |=> (sh == CG_K));

  // R9
  raw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_ack && raw_now) |=> (frm == F_IDLE && raw_q));
endmodule

// File: tb/sim_mlt3_tx_path.sv
module sim_mlt3_tx_path;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, tx_er = 1'b0, raw_mode = 1'b0, aneg_en = 1'b0;
  logic [3:0] txd = 4'h0;
  logic nib_ack;
  logic [1:0] line_lvl;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mlt3_tx_path u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .raw_mode(raw_mode), .aneg_en(aneg_en), .nib_ack(nib_ack), .line_lvl(line_lvl)
  );

  logic [4:0]  m_grp = 5'b11111;
  logic        m_raw = 1'b0;
  logic [10:0] m_scr = 11'h7FF;
  logic [1:0]  m_ph  = 2'd0;
  int          m_st  = 0;
  string       m_tag = "R1";

  function automatic logic [4:0] tbl(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic logic [1:0] lvl_of(input logic [1:0] p);
    return (p == 2'd1) ? 2'b01 : (p == 2'd3) ? 2'b11 : 2'b00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic slot(input bit en, input bit er, input logic [3:0] d,
                      input bit raw, input bit an, input string tag);
    logic b, k;
    tx_en = en; tx_er = er; txd = d; raw_mode = raw; aneg_en = an;
    for (int i = 0; i < 5; i++) begin
      chk(line_lvl == lvl_of(m_ph), {m_tag, " R8 line level"}, line_lvl, lvl_of(m_ph));
      chk(nib_ack == (i == 4), "R2 nib_ack slot position", nib_ack, (i == 4));
      k = m_scr[10] ^ m_scr[8];
      b = m_grp[4-i] ^ (k & ~m_raw);
      m_scr = {m_scr[9:0], k};
      if (b) m_ph = m_ph + 2'd1;
      if (i == 4) begin
        m_tag = tag;
        m_raw = raw & ~an;
        if (m_raw) begin
          m_grp = {er, d};
          m_st = 0;
        end else begin
          case (m_st)
            0: if (en) begin m_grp = 5'b11000; m_st = 1; end
               else m_grp = 5'b11111;
            1: begin m_grp = 5'b10001; m_st = 2; end
            2: if (en) m_grp = er ? 5'b00100 : tbl(d);
               else begin m_grp = 5'b01101; m_st = 3; end
            default: begin m_grp = 5'b00111; m_st = 0; end
          endcase
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(line_lvl == 2'b00, "R1 reset level", line_lvl, 0);
    chk(nib_ack == 1'b0, "R1 reset nib_ack", nib_ack, 0);
    rst_n = 1'b1;
    // R1, R5: idle, including error strobe and data outside a frame
    slot(0, 0, 4'h0, 0, 0, "R1");
    slot(0, 1, 4'h5, 0, 0, "R5");
    slot(0, 0, 4'hA, 0, 0, "R5");
    // R4, R3, R5: full frame over all nibbles
    slot(1, 0, 4'h5, 0, 0, "R4");
    slot(1, 0, 4'h5, 0, 0, "R4");
    for (int n = 0; n < 16; n++) slot(1, 0, 4'(n), 0, 0, "R3");
    slot(0, 0, 4'h0, 0, 0, "R5");
    slot(0, 0, 4'h0, 0, 0, "R5");
    slot(0, 0, 4'h0, 0, 0, "R5");
    // R6: error strobe mid-frame
    slot(1, 0, 4'h0, 0, 0, "R4");
    slot(0, 0, 4'h0, 0, 0, "R4");
    slot(1, 0, 4'h3, 0, 0, "R3");
    slot(1, 1, 4'h3, 0, 0, "R6");
    slot(1, 1, 4'hF, 0, 0, "R6");
    slot(1, 0, 4'hC, 0, 0, "R3");
    slot(0, 1, 4'h0, 0, 0, "R5");
    slot(0, 0, 4'h0, 0, 0, "R5");
    // R9: raw groups, tx_en toggled and ignored
    for (int v = 0; v < 32; v++) slot(v[0] ^ v[2], v[4], 4'(v), 1, 0, "R9");
    // R9: raw mode entered mid-frame resets framing
    slot(1, 0, 4'h0, 0, 0, "R4");
    slot(1, 0, 4'h0, 0, 0, "R4");
    slot(1, 0, 4'h7, 0, 0, "R3");
    slot(1, 0, 4'h9, 1, 0, "R9");
    slot(1, 1, 4'h2, 1, 0, "R9");
    slot(1, 0, 4'h1, 0, 0, "R9");
    slot(1, 0, 4'h1, 0, 0, "R9");
    slot(1, 0, 4'h8, 0, 0, "R3");
    slot(0, 0, 4'h0, 0, 0, "R5");
    slot(0, 0, 4'h0, 0, 0, "R5");
    // R10: auto-negotiation blocks raw mode
    slot(0, 1, 4'h3, 1, 1, "R10");
    slot(1, 0, 4'h0, 1, 1, "R10");
    slot(1, 0, 4'h0, 1, 1, "R10");
    slot(1, 0, 4'h4, 1, 1, "R10");
    slot(1, 1, 4'h4, 1, 1, "R10");
    slot(0, 0, 4'h0, 1, 1, "R10");
    slot(0, 0, 4'h0, 1, 1, "R10");
    slot(0, 0, 4'h0, 0, 0, "R7");
    slot(0, 0, 4'h0, 0, 0, "R7");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule